// File: doc/BRIEF.md
# Edge-Triggered Interrupt Controller with Countdown Timer

This block gathers interrupt requests for a small processor core. Each of the upper request lines is watched for a low-to-high transition. A detected transition is held in a pending register until the core acknowledges it. Line 0 has no external source. A built-in one-shot countdown timer drives it instead, and fires a fixed number of clock cycles after software loads it. A 32-bit block mask and a global enable decide whether the core sees a request.

The core reads `irq_vec_o`, which holds every pending bit that is not blocked. Software chooses among those bits itself, because the block applies no hardware priority. On entering a handler, the core issues an acknowledge command that names the bits it is taking. The block then refuses to raise the request again until a return command. This means handlers never nest.

All control goes through a single-cycle command port. `wr_op_i` selects the action and `wr_data_i` carries its operand. The command codes are: 0 write the whole mask, 1 block one line by index, 2 allow one line by index, 3 load the timer, 4 write the global enable (operand bit 0), 5 acknowledge and enter the handler, 6 return from the handler, 7 no action.

Top module: `irqc_top`

## Requirements
- R1: A 0-to-1 transition on `irq_i[n]` (n ≥ 1) sets pending bit n at the clock edge where the input is first sampled high. Holding the input high, or letting it fall, sets nothing further.
- R2: Mask bit value 1 blocks a line and 0 allows it. `irq_vec_o` shows pending bits whose mask bit is 0.
- R3: A pending bit stays set while its line is blocked, and appears on `irq_vec_o` as soon as the line is allowed again.
- R4: Command 5 clears exactly the pending bits set in `wr_data_i` and marks a handler active (`active_o` = 1). No other command clears a pending bit.
- R5: While a handler is active, `irq_req_o` is 0 even with unblocked pending bits. Command 6 ends the handler, and the request returns at once if bits are still pending.
- R6: The global enable, which resets to 0, gates `irq_req_o`. Edge capture continues while it is 0.
- R7: Command 3 with a value N > 0 makes `timer_o` read N after that edge and count down by one per cycle. Pending bit 0 sets at the edge where the count reaches 0, N cycles after the load. The timer then stays at 0 and does not reload.
- R8: Loading the value 0 stops the timer, including one already running, and no line-0 interrupt follows.
- R9: Commands 1 and 2 set or clear only the mask bit indexed by `wr_data_i[4:0]` and leave the other 31 bits unchanged.
- R10: `irq_i[0]` has no effect. Line 0 is driven only by the timer.
- R11: After reset, pending is all 0, the mask is all 1 (every line blocked), the global enable is 0, no handler is active and the timer reads 0.
- R12: When a line's new edge arrives on the same edge as an acknowledge of that line, the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Interrupt request lines; bit 0 unused |
| wr_en_i | input | 1 | Command strobe |
| wr_op_i | input | 3 | Command code (see above) |
| wr_data_i | input | 32 | Command operand |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 32 | Pending and unblocked lines |
| mask_o | output | 32 | Current block mask |
| timer_o | output | 32 | Remaining timer cycles |
| active_o | output | 1 | Handler in progress |

## Verification
A lost or spurious pending bit shows on `irq_vec_o` one cycle after the edge or command responsible, provided the line is unblocked. A stuck handler flag or enable shows immediately as a missing or unwanted `irq_req_o`. Timer errors show in `timer_o` on the very next cycle, and in pending bit 0 at the exact cycle the count expires. A mask update that spills into a neighbouring bit is visible directly on `mask_o`.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    OP_MASK_WR    = 3'd0,
    OP_MASK_BLOCK = 3'd1,
    OP_MASK_ALLOW = 3'd2,
    OP_TIMER_LD   = 3'd3,
    OP_GEN_WR     = 3'd4,
    OP_ACK        = 3'd5,
    OP_RET        = 3'd6,
    OP_NOP        = 3'd7
  } irqc_op_e;
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int N_LINES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] src_i,
  output logic [N_LINES-1:0] rise_o
);
  logic [N_LINES-1:0] prev_q;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= src_i[g];
    end
    assign rise_o[g] = src_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/irqc_timer.sv
module irqc_timer #(
  parameter int TIMER_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_i,
  input  logic [TIMER_W-1:0] ld_val_i,
  output logic [TIMER_W-1:0] cnt_o,
  output logic               fire_o
);
  logic [TIMER_W-1:0] cnt_q;

  // fires on the edge the count goes 1 -> 0; a load overrides
  assign fire_o = (cnt_q == TIMER_W'(1)) && !ld_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (ld_i)          cnt_q <= ld_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - TIMER_W'(1);
  end
endmodule

// File: rtl/irqc_ctl.sv
module irqc_ctl #(
  parameter int N_LINES = 32,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] set_i,
  input  logic               mask_wr_i,
  input  logic               mask_blk_i,
  input  logic               mask_alw_i,
  input  logic               gen_wr_i,
  input  logic               ack_i,
  input  logic               ret_i,
  input  logic [N_LINES-1:0] data_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               gen_val_i,
  output logic [N_LINES-1:0] pend_o,
  output logic [N_LINES-1:0] mask_o,
  output logic               gen_en_o,
  output logic               active_o
);
  logic [N_LINES-1:0] pend_q, mask_q, ack_clr;
  logic               gen_q, act_q;

  assign ack_clr = ack_i ? data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '1;
      gen_q  <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      // new edge wins over a simultaneous acknowledge
      pend_q <= (pend_q & ~ack_clr) | set_i;
      if (mask_wr_i)       mask_q        <= data_i;
      else if (mask_blk_i) mask_q[idx_i] <= 1'b1;
      else if (mask_alw_i) mask_q[idx_i] <= 1'b0;
      if (gen_wr_i) gen_q <= gen_val_i;
      if (ack_i)      act_q <= 1'b1;
      else if (ret_i) act_q <= 1'b0;
    end
  end

  assign pend_o   = pend_q;
  assign mask_o   = mask_q;
  assign gen_en_o = gen_q;
  assign active_o = act_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int TIMER_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_op_i,
  input  logic [N_LINES-1:0] wr_data_i,
  output logic               irq_req_o,
  output logic [N_LINES-1:0] irq_vec_o,
  output logic [N_LINES-1:0] mask_o,
  output logic [TIMER_W-1:0] timer_o,
  output logic               active_o
);
  localparam int IDX_W = $clog2(N_LINES);
  localparam logic [N_LINES-1:0] EXT_LINES = ~N_LINES'(1);

  irqc_op_e           op;
  logic [N_LINES-1:0] rise, set_vec, pend_q, mask_q;
  logic               fire, gen_en_q, active_q;
  logic               s_mwr, s_mblk, s_malw, s_tld, s_gen, s_ack, s_ret;

  assign op     = irqc_op_e'(wr_op_i);
  assign s_mwr  = wr_en_i && (op == OP_MASK_WR);
  assign s_mblk = wr_en_i && (op == OP_MASK_BLOCK);
  assign s_malw = wr_en_i && (op == OP_MASK_ALLOW);
  assign s_tld  = wr_en_i && (op == OP_TIMER_LD);
  assign s_gen  = wr_en_i && (op == OP_GEN_WR);
  assign s_ack  = wr_en_i && (op == OP_ACK);
  assign s_ret  = wr_en_i && (op == OP_RET);

  irqc_edge #(.N_LINES(N_LINES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (irq_i),
    .rise_o(rise)
  );

  irqc_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (s_tld),
    .ld_val_i(TIMER_W'(wr_data_i)),
    .cnt_o   (timer_o),
    .fire_o  (fire)
  );

  // line 0 belongs to the timer; external bit 0 is discarded
  assign set_vec = (rise & EXT_LINES) | {{(N_LINES-1){1'b0}}, fire};

  irqc_ctl #(.N_LINES(N_LINES)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .mask_wr_i (s_mwr),
    .mask_blk_i(s_mblk),
    .mask_alw_i(s_malw),
    .gen_wr_i  (s_gen),
    .ack_i     (s_ack),
    .ret_i     (s_ret),
    .data_i    (wr_data_i),
    .idx_i     (wr_data_i[IDX_W-1:0]),
    .gen_val_i (wr_data_i[0]),
    .pend_o    (pend_q),
    .mask_o    (mask_q),
    .gen_en_o  (gen_en_q),
    .active_o  (active_q)
  );

  assign irq_vec_o = pend_q & ~mask_q;
  assign irq_req_o = gen_en_q && !active_q && (|irq_vec_o);
  assign mask_o    = mask_q;
  assign active_o  = active_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N_LINES = 32,
  parameter int TIMER_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [2:0]         wr_op_i,
  input logic               irq_req_o,
  input logic [N_LINES-1:0] irq_vec_o,
  input logic [N_LINES-1:0] mask_o,
  input logic [TIMER_W-1:0] timer_o,
  input logic               active_o,
  input logic               gen_en_i
);
  logic vec_may_drop, tld;
  assign vec_may_drop = wr_en_i && (wr_op_i inside {3'd0, 3'd1, 3'd2, 3'd5});
  assign tld          = wr_en_i && (wr_op_i == 3'd3);

  AST_NO_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> !irq_req_o); // R5
  AST_GLOBAL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_en_i |-> !irq_req_o); // R6
  AST_PEND_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_may_drop |=> ((irq_vec_o & $past(irq_vec_o)) == $past(irq_vec_o))); // R4
  AST_TIMER_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_o != '0 && !tld) |=> (timer_o == $past(timer_o) - TIMER_W'(1))); // R7
  AST_TIMER_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_o == '0 && !tld) |=> (timer_o == '0)); // R8
  AST_ONE_MASK_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_op_i == 3'd1 || wr_op_i == 3'd2)) |=>
      ($countones(mask_o ^ $past(mask_o)) <= 1)); // R9
endmodule

bind irqc_top irqc_checker #(.N_LINES(N_LINES), .TIMER_W(TIMER_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_op_i  (wr_op_i),
  .irq_req_o(irq_req_o),
  .irq_vec_o(irq_vec_o),
  .mask_o   (mask_o),
  .timer_o  (timer_o),
  .active_o (active_o),
  .gen_en_i (gen_en_q)
);

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_op_i = 3'd7;
  logic [31:0] wr_data_i = '0;
  logic        irq_req_o, active_o;
  logic [31:0] irq_vec_o, mask_o, timer_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  irqc_top uut (.*);

  // {req tag, op, data, irq_i, exp vec, exp req}
  localparam int NSTEP = 18;
  localparam logic [103:0] TBL [NSTEP] = '{
    {4'd6,  3'd4, 32'h1,   32'h0,   32'h0,   1'b0}, // R6 enable on
    {4'd2,  3'd0, 32'h0,   32'h0,   32'h0,   1'b0}, // R2 allow all
    {4'd1,  3'd7, 32'h0,   32'h4,   32'h4,   1'b1}, // R1 rise line 2
    {4'd1,  3'd7, 32'h0,   32'h4,   32'h4,   1'b1}, // R1 held high
    {4'd4,  3'd5, 32'h4,   32'h4,   32'h0,   1'b0}, // R4 ack line 2
    {4'd1,  3'd7, 32'h0,   32'h0,   32'h0,   1'b0}, // R1 falling edge
    {4'd5,  3'd7, 32'h0,   32'h10,  32'h10,  1'b0}, // R5 edge while active
    {4'd5,  3'd6, 32'h0,   32'h10,  32'h10,  1'b1}, // R5 return
    {4'd9,  3'd1, 32'h4,   32'h10,  32'h0,   1'b0}, // R9 block line 4
    {4'd3,  3'd7, 32'h0,   32'h10,  32'h0,   1'b0}, // R3 still blocked
    {4'd3,  3'd2, 32'h4,   32'h10,  32'h10,  1'b1}, // R3 allowed again
    {4'd6,  3'd4, 32'h0,   32'h10,  32'h10,  1'b0}, // R6 enable off
    {4'd6,  3'd7, 32'h0,   32'h110, 32'h110, 1'b0}, // R6 capture continues
    {4'd6,  3'd4, 32'h1,   32'h110, 32'h110, 1'b1}, // R6 enable on
    {4'd4,  3'd5, 32'h100, 32'h110, 32'h10,  1'b0}, // R4 partial ack
    {4'd5,  3'd6, 32'h0,   32'h110, 32'h10,  1'b1}, // R5 return
    {4'd4,  3'd5, 32'h10,  32'h0,   32'h0,   1'b0}, // R4 ack line 4
    {4'd10, 3'd6, 32'h0,   32'h1,   32'h0,   1'b0}  // R10 line 0 input
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [31:0] data, input logic [31:0] irq);
    wr_en_i   = (op != 3'd7);
    wr_op_i   = op;
    wr_data_i = data;
    irq_i     = irq;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    wr_op_i = 3'd7;
  endtask

  task automatic nops(input int n, input logic [31:0] irq);
    for (int i = 0; i < n; i++) step(3'd7, 32'h0, irq);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    chk("R11 mask", mask_o, 32'hFFFF_FFFF);
    chk("R11 vec", irq_vec_o, 32'h0);
    chk("R11 timer", timer_o, 32'h0);
    chk("R11 req/active", {30'h0, irq_req_o, active_o}, 32'h0);

    for (int s = 0; s < NSTEP; s++) begin
      step(TBL[s][99:97], TBL[s][96:65], TBL[s][64:33]);
      checks++;
      if (irq_vec_o !== TBL[s][32:1] || irq_req_o !== TBL[s][0]) begin
        errors++;
        $display("FAIL R%0d step %0d actual vec %h req %b expected vec %h req %b",
                 TBL[s][103:100], s, irq_vec_o, irq_req_o, TBL[s][32:1], TBL[s][0]);
      end
    end

    // R7 one-shot timer, N = 5
    step(3'd3, 32'd5, 32'h0);
    chk("R7 timer loaded", timer_o, 32'd5);
    nops(4, 32'h0);
    chk("R7 timer at 1", timer_o, 32'd1);
    chk("R7 not yet fired", irq_vec_o, 32'h0);
    nops(1, 32'h0);
    chk("R7 timer expired", timer_o, 32'd0);
    chk("R7 line 0 pending", irq_vec_o, 32'h1);
    chk("R7 request", {31'h0, irq_req_o}, 32'h1);
    nops(3, 32'h0);
    chk("R7 no reload", timer_o, 32'd0);
    step(3'd5, 32'h1, 32'h0);
    step(3'd6, 32'h0, 32'h0);
    chk("R7 cleared", irq_vec_o, 32'h0);

    // R8 cancel a running timer
    step(3'd3, 32'd3, 32'h0);
    step(3'd3, 32'd0, 32'h0);
    nops(5, 32'h0);
    chk("R8 timer stopped", timer_o, 32'd0);
    chk("R8 no line 0", irq_vec_o, 32'h0);

    // R9 single-bit mask edits
    step(3'd0, 32'h0F0F_0F0F, 32'h0);
    step(3'd1, 32'd31, 32'h0);
    chk("R9 block bit 31", mask_o, 32'h8F0F_0F0F);
    step(3'd2, 32'd0, 32'h0);
    chk("R9 allow bit 0", mask_o, 32'h8F0F_0F0E);

    // R12 edge coinciding with ack of same line
    step(3'd5, 32'h40, 32'h40);
    chk("R12 bit kept", irq_vec_o, 32'h40);
    chk("R12 active", {31'h0, active_o}, 32'h1);
    step(3'd6, 32'h0, 32'h40);
    step(3'd5, 32'h40, 32'h40);
    chk("R4 held input no re-set", irq_vec_o, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule